// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits on a synchronous host clock and turns single-byte read and write requests into correctly timed strobe sequences for an asynchronous static RAM. The RAM side has a 17-bit address, an 8-bit data bus split into separate in, out and output-enable nets, and active-low chip-select (`mem_ce_n`), output-gate (`mem_oe_n`) and write-strobe (`mem_we_n`) lines.

The RAM decodes its mode from the strobes as follows:

- Chip-select high means standby, and the RAM leaves its bus undriven.
- Chip-select low with the write strobe low means a write.
- Chip-select low, the output gate low and the write strobe high means a read.
- Chip-select low with both the gate and the write strobe high means an active cycle with the bus undriven.

Every analog minimum (pulse widths, setup, hold and turnaround) is a nanosecond parameter. The block turns each one into clock cycles as ceil(ns / CLK_NS).

The host presents a request with `req_valid`, `req_write`, `req_addr` and `req_wdata`. The request is taken on the clock edge where `req_ready` is also high. Each request ends with a one-cycle `done` pulse, and read data appears on `rd_data`.

The block is a five-state machine:

- ST_IDLE: no strobes are active and `req_ready` is high. The transition taken on a request goes to ST_WR_PULSE or ST_RD_ACCESS.
- ST_WR_PULSE: chip-select and write strobe are low. The transition on timer expiry goes to ST_WR_HOLD.
- ST_WR_HOLD: the write strobe has returned high while chip-select is still low. The transition on timer expiry goes to ST_IDLE and raises `done`.
- ST_RD_ACCESS: chip-select and output gate are low. The transition on timer expiry captures the data, raises `done` and goes to ST_RD_RELEASE.
- ST_RD_RELEASE: all strobes are high while the RAM lets go of the bus. The transition on timer expiry goes to ST_IDLE.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and after reset, the outputs take these values: `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1; `mem_dq_oe` is 0; `done` is 0; `rd_data` is 0; `req_ready` is 1.
- R2: `req_ready` is 1 only in ST_IDLE. A request is taken on the clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the request has finished.
- R3: A write drops `mem_ce_n` and `mem_we_n` together on the accept edge and keeps `mem_oe_n` at 1 throughout. `mem_we_n` stays low for PULSE cycles. PULSE is the largest of the following: the strobe width, address-valid-to-strobe-high, the write cycle time, and release time plus data setup. Each term is converted to cycles; at the defaults this gives 7 cycles at 10 ns.
- R4: `mem_dq_oe` rises ceil(25 ns) cycles after `mem_we_n` falls and stays high until `mem_ce_n` rises. It is never 1 while `mem_oe_n` is 0. Data is therefore driven for at least 30 ns before `mem_we_n` rises.
- R5: The write strobe always ends the write. `mem_we_n` rises while `mem_ce_n` stays low for HOLD = max(1, ceil(5 ns)) further cycles. `mem_addr` does not change while `mem_ce_n` is low.
- R6: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for ACC cycles. ACC is the largest of the address, select, gate and read-cycle access times converted to cycles; at the defaults this is 7. `rd_data` loads `mem_dq_in` on the last edge of that window and keeps its value until the next read.
- R7: After a read, all strobes stay high and no request is taken for TURN = max(ceil(20 ns), ceil(30 ns)) cycles. At the defaults this is 3.
- R8: `done` is high for exactly one cycle. It rises PULSE+HOLD cycles after a write's accept edge (8 at the defaults) and ACC cycles after a read's accept edge (7 at the defaults).
- R9: A read returns the byte most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | RAM chip-select, active low |
| mem_oe_n | output | 1 | RAM output gate, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enables the pad driver for mem_dq_out |
| mem_dq_in | input | 8 | Data from the RAM |

## Verification
The assertions cover the relations that hold in every cycle:

- the gate is high whenever the write strobe is low;
- no data is driven while the gate is open;
- the address holds still while chip-select is low;
- the write strobe rises before chip-select;
- `done` is a single-cycle pulse;
- `rd_data` changes only on a completion.

The cycle counts need a timed RAM model in the bench. These are the strobe widths, the data setup before the strobe rises, the release delay before driving, the read access delay and the read-to-write turnaround. The model returns filler bytes until the access time has passed and logs any minimum that is not met. Completion latency, the end-to-end data path and the behaviour at the two address extremes are shown only by the bench's scenarios.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_RELEASE
    } ctrl_state_t;

    // Round a nanosecond minimum up to whole clock cycles.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] remaining,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign remaining = cnt_q;
    assign expired   = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_capture.sv
module sram_ctrl_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout <= '0;
        else if (capture)
            dout <= din;
    end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 17,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CLK_NS     = 10,
    parameter int unsigned T_WP_NS    = 55,  // write strobe width
    parameter int unsigned T_AW_NS    = 65,  // address valid to strobe high
    parameter int unsigned T_WC_NS    = 70,  // write cycle
    parameter int unsigned T_DS_NS    = 30,  // data setup to strobe high
    parameter int unsigned T_WLQZ_NS  = 25,  // RAM release after strobe low
    parameter int unsigned T_WAH_NS   = 5,   // address hold after strobe high
    parameter int unsigned T_AA_NS    = 70,  // address access
    parameter int unsigned T_ACE_NS   = 70,  // select access
    parameter int unsigned T_OE_NS    = 35,  // gate access
    parameter int unsigned T_RC_NS    = 70,  // read cycle
    parameter int unsigned T_OHZ_NS   = 20,  // release after gate high
    parameter int unsigned T_CHZ_NS   = 30   // release after select high
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned C_WLQZ    = ns_to_cyc(T_WLQZ_NS, CLK_NS);
    localparam int unsigned PULSE_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                             max2(ns_to_cyc(T_WC_NS, CLK_NS), C_WLQZ + ns_to_cyc(T_DS_NS, CLK_NS)));
    localparam int unsigned HOLD_CYC  = max2(1, ns_to_cyc(T_WAH_NS, CLK_NS));
    localparam int unsigned ACC_CYC   = max2(1, max2(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_ACE_NS, CLK_NS)),
                                                     max2(ns_to_cyc(T_OE_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS))));
    localparam int unsigned TURN_CYC  = max2(1, max2(ns_to_cyc(T_OHZ_NS, CLK_NS), ns_to_cyc(T_CHZ_NS, CLK_NS)));
    localparam int unsigned MAX_CYC   = max2(max2(PULSE_CYC, HOLD_CYC), max2(ACC_CYC, TURN_CYC));
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
    // Drive once C_WLQZ cycles of the pulse have elapsed (down-counter view).
    localparam int unsigned DRIVE_AT  = PULSE_CYC - 1 - C_WLQZ;

    ctrl_state_t       state_q, state_d;
    logic              accept, capture, done_d, tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val, tmr_left;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              done_q;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .load_val  (tmr_val),
        .remaining (tmr_left),
        .expired   (tmr_expired)
    );

    sram_ctrl_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (mem_dq_in),
        .dout    (rd_data)
    );

    // Next-state and event decode.
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        capture = 1'b0;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                accept  = 1'b1;
                state_d = req_write ? ST_WR_PULSE : ST_RD_ACCESS;
            end
            ST_WR_PULSE:   if (tmr_expired) state_d = ST_WR_HOLD;
            ST_WR_HOLD:    if (tmr_expired) begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            ST_RD_ACCESS:  if (tmr_expired) begin
                state_d = ST_RD_RELEASE;
                capture = 1'b1;
                done_d  = 1'b1;
            end
            ST_RD_RELEASE: if (tmr_expired) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Load the dwell count of the state being entered.
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_WR_PULSE:   tmr_val = CNT_W'(PULSE_CYC - 1);
            ST_WR_HOLD:    tmr_val = CNT_W'(HOLD_CYC - 1);
            ST_RD_ACCESS:  tmr_val = CNT_W'(ACC_CYC - 1);
            ST_RD_RELEASE: tmr_val = CNT_W'(TURN_CYC - 1);
            default:       tmr_val = '0;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // Strobe outputs decoded from the state register.
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:       req_ready = 1'b1;
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = (tmr_left <= CNT_W'(DRIVE_AT));
            end
            ST_WR_HOLD: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_RD_ACCESS: begin
                mem_ce_n  = 1'b0;
                mem_oe_n  = 1'b0;
            end
            ST_RD_RELEASE: ;
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign done       = done_q;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    // R3
    write_gate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    // R4
    drive_no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    // R5
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R5
    strobe_ends_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_ce_n);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    accept_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));

    // R6
    rd_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);

    // R7
    write_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_oe_n));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .rd_data   (rd_data),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_cycle_ctrl_bench.sv
module sram_cycle_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 8;

    function automatic int ceil_cyc(input int ns);
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_PULSE = imax(imax(ceil_cyc(55), ceil_cyc(65)), imax(ceil_cyc(70), ceil_cyc(25) + ceil_cyc(30)));
    localparam int EXP_HOLD  = imax(1, ceil_cyc(5));
    localparam int EXP_ACC   = imax(imax(ceil_cyc(70), ceil_cyc(70)), ceil_cyc(35));
    localparam int EXP_TURN  = imax(ceil_cyc(20), ceil_cyc(30));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, done;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hEE;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] sram   [int unsigned];
    logic [DW-1:0] shadow [int unsigned];
    logic [DW-1:0] last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_cycle_ctrl u_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fill_byte(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'hA5;
    endfunction

    // Timed RAM model: counts strobe cycles and flags unmet minimums.
    int wl_cnt = 0, drv_cnt = 0, rd_cnt = 0, since_oe = 100, since_we = 100;
    logic p_ce = 1'b1, p_we = 1'b1;
    logic [AW-1:0] p_addr = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            wl_cnt = 0; drv_cnt = 0; rd_cnt = 0; since_oe = 100; since_we = 100;
            p_ce = 1'b1; p_we = 1'b1; p_addr = mem_addr;
        end else begin
            if (mem_we_n) since_we++;
            if (mem_oe_n) since_oe++; else since_oe = 0;
            if (!p_we && mem_we_n && !p_ce) begin
                chk(wl_cnt * CLK_PERIOD >= 55, "R3", "strobe width ns", wl_cnt * CLK_PERIOD, 55);
                chk(wl_cnt * CLK_PERIOD >= 70, "R3", "addr-to-strobe-high/cycle ns", wl_cnt * CLK_PERIOD, 70);
                chk(drv_cnt * CLK_PERIOD >= 30, "R4", "data setup ns", drv_cnt * CLK_PERIOD, 30);
                chk(!mem_ce_n && mem_dq_oe, "R5", "select/data after strobe rise", {mem_ce_n, mem_dq_oe}, 1);
                if (drv_cnt > 0) sram[p_addr] = mem_dq_out;
                wl_cnt = 0; drv_cnt = 0; since_we = 0;
            end
            if (!p_ce && mem_ce_n && !p_we)
                chk(0, "R5", "select ended the write", 1, 0);
            if (mem_addr != p_addr) begin
                if (!p_ce && !mem_ce_n) chk(0, "R5", "address moved while selected", mem_addr, p_addr);
                if (since_we * CLK_PERIOD < 5) chk(0, "R5", "address hold ns", since_we * CLK_PERIOD, 5);
            end
            if (!mem_ce_n && !mem_we_n) begin
                wl_cnt++;
                if (!mem_oe_n) chk(0, "R3", "gate low in write", 0, 1);
                if (wl_cnt == 1) chk((since_oe - 1) * CLK_PERIOD >= 20, "R7", "turnaround ns", (since_oe - 1) * CLK_PERIOD, 20);
                if (mem_dq_oe) begin
                    if (drv_cnt == 0)
                        chk((wl_cnt - 1) * CLK_PERIOD >= 25, "R4", "drive start ns", (wl_cnt - 1) * CLK_PERIOD, 25);
                    drv_cnt++;
                end
            end
            if (!mem_ce_n && !mem_oe_n && mem_dq_oe) chk(0, "R4", "bus contention", 1, 0);
            if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
                rd_cnt++;
                mem_dq_in = (rd_cnt * CLK_PERIOD >= 70)
                          ? (sram.exists(mem_addr) ? sram[mem_addr] : fill_byte(mem_addr)) : 8'hEE;
            end else begin
                rd_cnt = 0;
                mem_dq_in = 8'hEE;
            end
            p_ce = mem_ce_n; p_we = mem_we_n; p_addr = mem_addr;
        end
    end

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat;
        logic [DW-1:0] exp_b;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~d;
        lat = 0;
        while (!done && lat < 60) begin
            if (lat == 2) chk(!req_ready, "R2", "ready while busy", req_ready, 0);
            @(negedge clk);
            lat++;
        end
        chk(lat == (wr ? EXP_PULSE + EXP_HOLD : EXP_ACC), "R8", "done latency", lat,
            wr ? EXP_PULSE + EXP_HOLD : EXP_ACC);
        if (wr) begin
            shadow[a] = d;
            chk(rd_data == last_rd, "R6", "rd_data held over write", rd_data, last_rd);
        end else begin
            exp_b = shadow.exists(a) ? shadow[a] : fill_byte(a);
            chk(rd_data == exp_b, "R9", "read data", rd_data, exp_b);
            last_rd = exp_b;
        end
        @(negedge clk);
        chk(!done, "R8", "done width", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1", "strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe && !done && rd_data == 0, "R1", "drive/done/rd_data in reset", {mem_dq_oe, done, rd_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);
        chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1", "idle strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 7);

        // R9 directed: extremes of the address range, unwritten read, overwrite.
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b1, 17'h00000, 8'h5C);
        do_op(1'b1, 17'h1FFFF, 8'hC3);
        do_op(1'b0, 17'h1FFFF, 8'h00);
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b1, 17'h00000, 8'hFF);
        do_op(1'b0, 17'h00000, 8'h00);

        // R7 directed: a read followed by a write must wait out the release.
        do_op(1'b0, 17'h00123, 8'h00);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00124; req_wdata = 8'h77;
        begin
            int waited = 0;
            while (!req_ready) begin @(negedge clk); waited++; end
            chk(waited == EXP_TURN - 2, "R7", "release cycles remaining", waited, EXP_TURN - 2);
        end
        req_valid = 1'b0;
        do_op(1'b1, 17'h00124, 8'h77);
        do_op(1'b0, 17'h00124, 8'h00);

        // Random mix over a small pool so reads hit written bytes.
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            a = {9'd0, 8'($urandom_range(0, 15))} | (($urandom_range(0, 3) == 0) ? 17'h1FF00 : 17'h0);
            do_op(1'($urandom_range(0, 1)), a, 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule